// File: doc/BRIEF.md
# Dual-Precision Aliased Shader Register File

This block is the temporary register storage of a pixel shader pipeline. A single array of storage can be addressed in two ways: as 32 wide registers of 32 bits (wide names W0..W31), or as 64 narrow registers of 16 bits (narrow names N0..N63). The register holds no record of the precision it was last written at. Every access carries a precision flag that comes from the opcode of the instruction that issued it, and that flag alone decides how the index is interpreted and which bits move.

Narrow names overlap wide names. N0..N31 are the low halves of W0..W31, and N32..N63 are the high halves of W0..W31. A narrow write therefore changes part of a wide register. Bits are copied unchanged in both directions: a half-precision pattern (sign, 5 exponent bits, 10 mantissa bits) written narrow is read back wide as the same 16 raw bits, and no format conversion takes place. The block has two read ports and one write port. Reads are registered and have one cycle of latency.

Top module: `rfa_dual_prec_regfile`

## Requirements
- R1: After reset every wide register reads as 0x00000000, and every narrow register reads as 0x00000000 on the 32-bit read bus.
- R2: A write with precision flag 0 (wide) stores all 32 bits of wr_data into W[idx[4:0]]. A wide read returns W[idx[4:0]]. In wide accesses, index bit 5 is ignored.
- R3: A narrow access (flag 1) with idx below 32 addresses bits 15:0 of W[idx]. A narrow write stores wr_data[15:0] there as raw bits.
- R4: A narrow access with idx of 32 or more addresses bits 31:16 of W[idx-32]. For example, a narrow write to index 32 lands in the upper half of W0.
- R5: A narrow write leaves the other 16 bits of the same wide register unchanged.
- R6: A narrow read returns the selected 16 bits on data[15:0], with data[31:16] equal to zero.
- R7: Read data appears on the read port's data output one clock edge after the index and flag are presented. The two read ports operate independently.
- R8: A read that addresses the register being written on the same edge returns the contents before the write. There is no bypass. The new value is visible to a read presented on the next edge.
- R9: While wr_en is low, no storage changes, whatever wr_idx, wr_half and wr_data hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write enable, sampled on the rising edge |
| wr_half | input | 1 | Write precision flag: 1 = narrow 16-bit, 0 = wide 32-bit |
| wr_idx | input | 6 | Write register index |
| wr_data | input | 32 | Write data (narrow writes use bits 15:0) |
| ra_half | input | 1 | Read port A precision flag |
| ra_idx | input | 6 | Read port A register index |
| ra_data | output | 32 | Read port A data, registered |
| rb_half | input | 1 | Read port B precision flag |
| rb_idx | input | 6 | Read port B register index |
| rb_data | output | 32 | Read port B data, registered |

## Verification
A read and a write to the same storage can fall on the same clock edge. This includes a narrow write paired with a wide read of the register it aliases, or a write to one half paired with a narrow read of the other half. The bench issues both in a single cycle, on both read ports. Its scoreboard expects the pre-write value on the following cycle, and the new value one cycle later. A long mixed stretch of random indices over a small register subset makes such overlaps common, and every result is judged against a bench-side model that is updated only after the expected read values have been taken.

// File: rtl/rfa_pkg.sv
package rfa_pkg;
  parameter int RFA_WIDE_W   = 32;
  parameter int RFA_NUM_WIDE = 32;
  parameter int RFA_NUM_RD   = 2;

  localparam int RFA_HALF_W = RFA_WIDE_W / 2;
  localparam int RFA_WIDX_W = $clog2(RFA_NUM_WIDE);
  localparam int RFA_IDX_W  = RFA_WIDX_W + 1;

  // Decoded location of one access within the split storage
  typedef struct packed {
    logic [RFA_WIDX_W-1:0] word;   // wide register number
    logic                  upper;  // narrow access to high half
    logic                  half;   // narrow access
  } rfa_loc_t;
endpackage

// File: rtl/rfa_rst_sync.sv
module rfa_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/rfa_loc_decode.sv
module rfa_loc_decode
  import rfa_pkg::*;
(
  input  logic [RFA_IDX_W-1:0] idx,
  input  logic                 half,
  output rfa_loc_t             loc
);
  always_comb begin
    loc.word  = idx[RFA_WIDX_W-1:0];
    loc.half  = half;
    // Top index bit picks the high half only for narrow accesses
    loc.upper = half & idx[RFA_IDX_W-1];
  end
endmodule

// File: rtl/rfa_bank.sv
module rfa_bank
  import rfa_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  rfa_loc_t              wloc,
  input  logic [RFA_WIDE_W-1:0] wdata,
  input  rfa_loc_t              rloc  [RFA_NUM_RD],
  output logic [RFA_WIDE_W-1:0] rword [RFA_NUM_RD]
);
  logic [RFA_HALF_W-1:0] lo_q [RFA_NUM_WIDE];
  logic [RFA_HALF_W-1:0] hi_q [RFA_NUM_WIDE];

  logic                  we_lo;
  logic                  we_hi;
  logic [RFA_HALF_W-1:0] wd_lo;
  logic [RFA_HALF_W-1:0] wd_hi;

  always_comb begin
    we_lo = we & (~wloc.half | ~wloc.upper);
    we_hi = we & (~wloc.half |  wloc.upper);
    wd_lo = wdata[RFA_HALF_W-1:0];
    wd_hi = wloc.half ? wdata[RFA_HALF_W-1:0] : wdata[RFA_WIDE_W-1:RFA_HALF_W];
  end

  for (genvar w = 0; w < RFA_NUM_WIDE; w++) begin : g_word
    logic                  sel;
    logic                  ce_lo;
    logic                  ce_hi;
    logic [RFA_HALF_W-1:0] lo_d;
    logic [RFA_HALF_W-1:0] hi_d;

    always_comb begin
      sel   = (wloc.word == RFA_WIDX_W'(w));
      ce_lo = we_lo & sel;
      ce_hi = we_hi & sel;
      lo_d  = ce_lo ? wd_lo : lo_q[w];
      hi_d  = ce_hi ? wd_hi : hi_q[w];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[w] <= '0;
        hi_q[w] <= '0;
      end else begin
        lo_q[w] <= lo_d;
        hi_q[w] <= hi_d;
      end
    end
  end

  for (genvar p = 0; p < RFA_NUM_RD; p++) begin : g_rd
    always_comb begin
      rword[p] = {hi_q[rloc[p].word], lo_q[rloc[p].word]};
    end
  end

  AST_WIDE_WRITE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wloc.half) |=>
      ({hi_q[$past(wloc.word)], lo_q[$past(wloc.word)]} == $past(wdata))); // R2

  AST_NARROW_LOW_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wloc.half && !wloc.upper) |=>
      (lo_q[$past(wloc.word)] == $past(wdata[RFA_HALF_W-1:0]))); // R3

  AST_NARROW_HIGH_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wloc.half && wloc.upper) |=>
      (hi_q[$past(wloc.word)] == $past(wdata[RFA_HALF_W-1:0]))); // R4

  AST_NARROW_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wloc.half && wloc.upper) |=>
      (lo_q[$past(wloc.word)] == $past(lo_q[wloc.word]))); // R5

  AST_NARROW_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wloc.half && !wloc.upper) |=>
      (hi_q[$past(wloc.word)] == $past(hi_q[wloc.word]))); // R5
endmodule

// File: rtl/rfa_rd_stage.sv
module rfa_rd_stage
  import rfa_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  rfa_loc_t              loc,
  input  logic [RFA_WIDE_W-1:0] word,
  output logic [RFA_WIDE_W-1:0] data_q
);
  logic [RFA_WIDE_W-1:0] data_d;
  logic [RFA_HALF_W-1:0] part;

  always_comb begin
    part   = loc.upper ? word[RFA_WIDE_W-1:RFA_HALF_W] : word[RFA_HALF_W-1:0];
    data_d = loc.half ? {{(RFA_WIDE_W-RFA_HALF_W){1'b0}}, part} : word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  AST_NARROW_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(loc.half) |-> (data_q[RFA_WIDE_W-1:RFA_HALF_W] == '0)); // R6
endmodule

// File: rtl/rfa_dual_prec_regfile.sv
module rfa_dual_prec_regfile
  import rfa_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_half,
  input  logic [RFA_IDX_W-1:0]  wr_idx,
  input  logic [RFA_WIDE_W-1:0] wr_data,
  input  logic                  ra_half,
  input  logic [RFA_IDX_W-1:0]  ra_idx,
  output logic [RFA_WIDE_W-1:0] ra_data,
  input  logic                  rb_half,
  input  logic [RFA_IDX_W-1:0]  rb_idx,
  output logic [RFA_WIDE_W-1:0] rb_data
);
  logic                  rst_n_s;
  rfa_loc_t              wloc;
  rfa_loc_t              rloc   [RFA_NUM_RD];
  logic [RFA_WIDE_W-1:0] rword  [RFA_NUM_RD];
  logic [RFA_WIDE_W-1:0] rdata  [RFA_NUM_RD];
  logic [RFA_IDX_W-1:0]  rd_idx [RFA_NUM_RD];
  logic                  rd_hf  [RFA_NUM_RD];

  always_comb begin
    rd_idx[0] = ra_idx;
    rd_hf[0]  = ra_half;
    rd_idx[1] = rb_idx;
    rd_hf[1]  = rb_half;
  end

  rfa_rst_sync u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  rfa_loc_decode u_wdec (
    .idx  (wr_idx),
    .half (wr_half),
    .loc  (wloc)
  );

  for (genvar p = 0; p < RFA_NUM_RD; p++) begin : g_port
    rfa_loc_decode u_rdec (
      .idx  (rd_idx[p]),
      .half (rd_hf[p]),
      .loc  (rloc[p])
    );

    rfa_rd_stage u_stage (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .loc    (rloc[p]),
      .word   (rword[p]),
      .data_q (rdata[p])
    );
  end

  rfa_bank u_bank (
    .clk   (clk),
    .rst_n (rst_n_s),
    .we    (wr_en),
    .wloc  (wloc),
    .wdata (wr_data),
    .rloc  (rloc),
    .rword (rword)
  );

  assign ra_data = rdata[0];
  assign rb_data = rdata[1];
endmodule

// File: tb/rfa_dual_prec_regfile_tb.sv
module rfa_dual_prec_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_half = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        ra_half = 1'b0;
  logic [5:0]  ra_idx = '0;
  logic        rb_half = 1'b0;
  logic [5:0]  rb_idx = '0;
  logic [31:0] ra_data;
  logic [31:0] rb_data;

  always #10 clk = ~clk;

  rfa_dual_prec_regfile u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_half(wr_half), .wr_idx(wr_idx), .wr_data(wr_data),
    .ra_half(ra_half), .ra_idx(ra_idx), .ra_data(ra_data),
    .rb_half(rb_half), .rb_idx(rb_idx), .rb_data(rb_data)
  );

  typedef struct {
    int          due;
    logic [31:0] exp_a;
    logic [31:0] exp_b;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  logic [31:0] model [32];
  int          cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] model_rd(input logic half, input logic [5:0] idx);
    logic [31:0] w;
    w = model[idx[4:0]];
    if (!half) return w;
    return idx[5] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
  endfunction

  task automatic issue(input logic we, input logic wh, input logic [5:0] wi,
                       input logic [31:0] wd, input logic ah, input logic [5:0] ai,
                       input logic bh, input logic [5:0] bi, input string tag);
    item_t it;
    @(posedge clk);
    #2;
    wr_en = we; wr_half = wh; wr_idx = wi; wr_data = wd;
    ra_half = ah; ra_idx = ai; rb_half = bh; rb_idx = bi;
    it.due   = cyc + 1;
    it.exp_a = model_rd(ah, ai);
    it.exp_b = model_rd(bh, bi);
    it.tag   = tag;
    sb_q.push_back(it);
    if (we) begin
      if (!wh)       model[wi[4:0]] = wd;
      else if (wi[5]) model[wi[4:0]][31:16] = wd[15:0];
      else           model[wi[4:0]][15:0] = wd[15:0];
    end
  endtask

  // Monitor: compares read results against scoreboard entries
  initial begin
    forever begin
      @(posedge clk);
      #12;
      while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
        item_t it;
        it = sb_q.pop_front();
        n_chk += 2;
        if (ra_data !== it.exp_a) begin
          n_fail++;
          $display("FAIL %s port A: actual %h expected %h", it.tag, ra_data, it.exp_a);
        end
        if (rb_data !== it.exp_b) begin
          n_fail++;
          $display("FAIL %s port B: actual %h expected %h", it.tag, rb_data, it.exp_b);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // r1_: reset state, wide on A, narrow upper on B
    for (int i = 0; i < 32; i++)
      issue(0, 0, 0, 0, 0, 6'(i), 1, 6'(i + 32), "R1 reset");
    // R1: narrow lower after reset
    issue(0, 0, 0, 0, 1, 6'd3, 1, 6'd31, "R1 reset narrow");

    // R2: wide writes and reads, bit 5 ignored on wide access
    issue(1, 0, 6'd5, 32'hDEADBEEF, 0, 0, 0, 0, "R2 write");
    issue(1, 0, 6'd31, 32'h12345678, 0, 6'd5, 0, 6'd37, "R2 read/bit5");
    issue(1, 0, 6'd39, 32'hAAAA5555, 0, 6'd31, 0, 6'd63, "R2 write bit5");
    issue(0, 0, 0, 0, 0, 6'd7, 0, 6'd39, "R2 readback");

    // R3 R5 R6: narrow low write keeps high half, zero-extended read
    issue(1, 1, 6'd7, 32'hFFFF3C00, 0, 6'd7, 1, 6'd7, "R3 before");
    issue(0, 0, 0, 0, 0, 6'd7, 1, 6'd7, "R3 R5 R6 after low");
    // R4 R5: narrow high write
    issue(1, 1, 6'd39, 32'h0000C000, 1, 6'd39, 1, 6'd7, "R4 before");
    issue(0, 0, 0, 0, 0, 6'd7, 1, 6'd39, "R4 R5 R6 after high");
    // R4: index 32 lands in upper half of W0
    issue(1, 1, 6'd32, 32'h00007BFF, 0, 0, 0, 0, "R4 N32");
    issue(0, 0, 0, 0, 0, 6'd0, 1, 6'd0, "R4 W0 upper");

    // R7: ports independent, one-cycle latency, back-to-back addresses
    issue(0, 0, 0, 0, 0, 6'd5, 0, 6'd31, "R7 a");
    issue(0, 0, 0, 0, 0, 6'd31, 1, 6'd37, "R7 b");

    // R8: collision returns old value, new value one cycle later
    issue(1, 0, 6'd9, 32'h0BADF00D, 0, 6'd9, 1, 6'd41, "R8 wide hit");
    issue(1, 1, 6'd41, 32'h00001234, 0, 6'd9, 1, 6'd41, "R8 narrow hit");
    issue(1, 1, 6'd9, 32'h00005678, 1, 6'd41, 1, 6'd9, "R8 other half");
    issue(0, 0, 0, 0, 0, 6'd9, 1, 6'd9, "R8 after");

    // R9: disabled write changes nothing
    issue(0, 0, 6'd9, 32'hFFFFFFFF, 0, 6'd9, 0, 0, "R9 wide off");
    issue(0, 1, 6'd32, 32'hFFFFFFFF, 0, 6'd9, 0, 6'd0, "R9 narrow off");
    issue(0, 0, 0, 0, 0, 6'd9, 0, 6'd0, "R9 readback");

    // Mixed random traffic on a small subset to force overlaps (R2-R8)
    for (int k = 0; k < 400; k++) begin
      logic [5:0] wi, ai, bi;
      wi = {1'($urandom), 5'($urandom % 4)};
      ai = {1'($urandom), 5'($urandom % 4)};
      bi = {1'($urandom), 5'($urandom % 4)};
      issue(1'($urandom), 1'($urandom), wi, $urandom, 1'($urandom), ai,
            1'($urandom), bi, "R2-mix R8 random");
    end
    issue(0, 0, 0, 0, 0, 0, 0, 0, "R7 drain");
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule